// File: doc/BRIEF.md
# Low-Speed USB Endpoint Transmit Handshake Controller

This block holds the transmit control state of two endpoints of a low-speed USB device. Endpoint 0 is the control endpoint. Endpoint 1 is a transmit-only endpoint that must be switched on by software. A processor writes and reads one control byte per endpoint through a simple register port. The serial interface engine reports decoded tokens (IN, OUT, SETUP), host acknowledgements and receive data errors. The block answers each token on the next cycle. The answer is a data packet with its byte count and DATA0/DATA1 selection, NAK, STALL, ACK, or silence.

A data answer opens an acknowledgement window of `ACK_TIMEOUT` cycles. A host ACK inside that window disarms the endpoint that sent the data and pulses that endpoint's interrupt for one cycle. If the ACK does not arrive inside the window, the endpoint stays armed, so the next IN repeats the same packet. Line coding, bit stuffing, CRC and the data buffer are handled by other blocks.

Each control byte is laid out as bits 3:0 byte count, bit 4 flag, bit 5 stall, bit 6 toggle and bit 7 arm. On endpoint 0 the flag is the receive-error flag. On endpoint 1 the flag is the enable. Token kind encoding: IN=0, OUT=1, SETUP=2. Response code encoding: NONE=0, DATA=1, NAK=2, STALL=3, ACK=4.

Top module: `usb_txhs_ctrl`

## Requirements
- R1: After reset, both control bytes read 0x00, `resp_valid`, `resp_code`, `ep0_irq` and `ep1_irq` are 0.
- R2: A write at address 0x10 (endpoint 0) or 0x11 (endpoint 1) stores the byte, which reads back unchanged on `reg_rdata`. Any other address reads 0x00.
- R3: An IN to an enabled, unstalled, armed endpoint (bit 7 = 1) gives, one cycle later, `resp_valid`=1 and code DATA (1). `resp_toggle` equals bit 6, and `resp_cnt` equals bits 3:0, with counts 9 to 15 sent as 8.
- R4: An IN to an enabled, unstalled endpoint whose arm bit is 0 is answered with NAK (2), with `resp_cnt` and `resp_toggle` 0.
- R5: With bit 5 set, an enabled endpoint answers both IN and OUT with STALL (3). On endpoint 1 the stall bit stays set until software writes it to 0.
- R6: A SETUP to endpoint 0 is answered with ACK (4) and clears bits 5 and 7 of the endpoint 0 byte, leaving the other bits unchanged. A SETUP to endpoint 1 gets no answer.
- R7: A `rx_err` pulse after a SETUP or OUT to endpoint 0, and before the next token, sets endpoint 0 bit 4. A `rx_err` at any other time changes nothing.
- R8: While endpoint 1 bit 4 is 0, every token to endpoint 1 gets no answer (`resp_valid`=0, code NONE).
- R9: A `host_ack` within `ACK_TIMEOUT` cycles of a DATA answer clears bit 7 of the endpoint that sent it, and pulses that endpoint's interrupt high for exactly one cycle, one cycle after the ACK.
- R10: A `host_ack` with no data outstanding, or one arriving after the window has closed, raises no interrupt and leaves the arm bit set, so the next IN is again answered with DATA.
- R11: An OUT to unstalled endpoint 0 is answered with ACK (4). An OUT to unstalled, enabled endpoint 1 gets no answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on address) |
| tok_valid | input | 1 | Token event strobe |
| tok_kind | input | 2 | Token kind: IN=0, OUT=1, SETUP=2 |
| tok_ep | input | 1 | Endpoint addressed by the token |
| host_ack | input | 1 | Host ACK received for transmitted data |
| rx_err | input | 1 | Received data packet had a CRC, PID or stuffing error |
| resp_valid | output | 1 | A handshake or data packet is to be sent |
| resp_code | output | 3 | Response: NONE=0, DATA=1, NAK=2, STALL=3, ACK=4 |
| resp_cnt | output | 4 | Byte count of the data packet |
| resp_toggle | output | 1 | 0 for DATA0, 1 for DATA1 |
| ep0_irq | output | 1 | Endpoint 0 transfer-done pulse |
| ep1_irq | output | 1 | Endpoint 1 transfer-done pulse |

## Verification
The response outputs are registered, so they are due on the edge that captures the token. Interrupts and arm clears are due on the edge that captures the ACK. Register reads are combinational, so a write shows on `reg_rdata` right after its capturing edge. The bench drives every input on a falling edge, drops the input at the next falling edge, and samples the outputs at that moment, half a cycle after the one edge that carries the result. The interrupt is checked again one cycle later to confirm that it is a single-cycle pulse. The timeout case waits `ACK_TIMEOUT`+4 cycles so that the window has certainly closed.

// File: rtl/usb_txhs_pkg.sv
package usb_txhs_pkg;

    typedef enum logic [1:0] {
        TK_IN    = 2'd0,
        TK_OUT   = 2'd1,
        TK_SETUP = 2'd2,
        TK_RSVD  = 2'd3
    } tok_kind_e;

    typedef enum logic [2:0] {
        RS_NONE  = 3'd0,
        RS_DATA  = 3'd1,
        RS_NAK   = 3'd2,
        RS_STALL = 3'd3,
        RS_ACK   = 3'd4
    } resp_e;

    // control byte: bit 7 arm, 6 toggle, 5 stall, 4 flag, 3:0 count
    typedef struct packed {
        logic       arm;
        logic       tog;
        logic       stall;
        logic       flag;
        logic [3:0] cnt;
    } ep_reg_t;

endpackage

// File: rtl/usb_txhs_resp.sv
module usb_txhs_resp
    import usb_txhs_pkg::*;
#(
    parameter int MAX_BYTES = 8
) (
    input  tok_kind_e  kind,
    input  logic       ep,
    input  ep_reg_t    ep0,
    input  ep_reg_t    ep1,
    output resp_e      code,
    output logic [3:0] cnt,
    output logic       tog
);
    localparam logic [3:0] CNT_MAX = 4'(MAX_BYTES);

    ep_reg_t sel;
    logic    live;

    always_comb begin
        sel  = ep ? ep1 : ep0;
        live = ep ? ep1.flag : 1'b1;
        code = RS_NONE;
        if (live) begin
            case (kind)
                TK_SETUP: code = ep ? RS_NONE : RS_ACK;
                TK_IN:    code = sel.stall ? RS_STALL : (sel.arm ? RS_DATA : RS_NAK);
                TK_OUT:   code = sel.stall ? RS_STALL : (ep ? RS_NONE : RS_ACK);
                default:  code = RS_NONE;
            endcase
        end
        cnt = '0;
        tog = 1'b0;
        if (code == RS_DATA) begin
            cnt = (sel.cnt > CNT_MAX) ? CNT_MAX : sel.cnt;
            tog = sel.tog;
        end
    end
endmodule

// File: rtl/usb_txhs_ack_win.sv
module usb_txhs_ack_win #(
    parameter int ACK_TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_ep,
    input  logic token,
    input  logic ack,
    output logic ack_hit,
    output logic ack_ep
);
    localparam int TW = $clog2(ACK_TIMEOUT + 1);

    typedef struct packed {
        logic          open;
        logic          ep;
        logic [TW-1:0] timer;
    } win_t;

    win_t d, q;

    assign ack_hit = q.open && ack;
    assign ack_ep  = q.ep;

    always_comb begin
        d = q;
        if (start) begin
            d.open  = 1'b1;
            d.ep    = start_ep;
            d.timer = TW'(ACK_TIMEOUT);
        end else if (token || ack_hit || (q.open && q.timer == '0)) begin
            d.open  = 1'b0;
            d.timer = '0;
        end else if (q.open) begin
            d.timer = q.timer - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/usb_txhs_ctrl.sv
module usb_txhs_ctrl
    import usb_txhs_pkg::*;
#(
    parameter int          ACK_TIMEOUT = 16,
    parameter int          MAX_BYTES   = 8,
    parameter logic [7:0]  EP0_ADDR    = 8'h10,
    parameter logic [7:0]  EP1_ADDR    = 8'h11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       tok_valid,
    input  logic [1:0] tok_kind,
    input  logic       tok_ep,
    input  logic       host_ack,
    input  logic       rx_err,
    output logic       resp_valid,
    output logic [2:0] resp_code,
    output logic [3:0] resp_cnt,
    output logic       resp_toggle,
    output logic       ep0_irq,
    output logic       ep1_irq
);
    typedef struct packed {
        ep_reg_t    ep0;
        ep_reg_t    ep1;
        logic       rx_open;
        logic       rvalid;
        resp_e      rcode;
        logic [3:0] rcnt;
        logic       rtog;
        logic       irq0;
        logic       irq1;
    } st_t;

    st_t d, q;

    tok_kind_e  kind;
    resp_e      sel_code;
    logic [3:0] sel_cnt;
    logic       sel_tog;
    logic       ack_hit, ack_ep;
    logic       start_win;

    // visible to the bound checker
    ep_reg_t ep0_q, ep1_q;
    assign ep0_q = q.ep0;
    assign ep1_q = q.ep1;

    assign kind      = tok_kind_e'(tok_kind);
    assign start_win = tok_valid && (sel_code == RS_DATA);

    usb_txhs_resp #(.MAX_BYTES(MAX_BYTES)) u_resp (
        .kind (kind),
        .ep   (tok_ep),
        .ep0  (q.ep0),
        .ep1  (q.ep1),
        .code (sel_code),
        .cnt  (sel_cnt),
        .tog  (sel_tog)
    );

    usb_txhs_ack_win #(.ACK_TIMEOUT(ACK_TIMEOUT)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_win),
        .start_ep (tok_ep),
        .token    (tok_valid),
        .ack      (host_ack),
        .ack_hit  (ack_hit),
        .ack_ep   (ack_ep)
    );

    always_comb begin
        d      = q;
        d.irq0 = 1'b0;
        d.irq1 = 1'b0;

        // software access first; hardware events below take precedence
        if (reg_we && reg_addr == EP0_ADDR) d.ep0 = ep_reg_t'(reg_wdata);
        if (reg_we && reg_addr == EP1_ADDR) d.ep1 = ep_reg_t'(reg_wdata);

        d.rvalid = tok_valid && (sel_code != RS_NONE);
        d.rcode  = tok_valid ? sel_code : RS_NONE;
        d.rcnt   = tok_valid ? sel_cnt  : 4'd0;
        d.rtog   = tok_valid && sel_tog;

        if (rx_err && q.rx_open) d.ep0.flag = 1'b1;

        if (tok_valid) begin
            d.rx_open = !tok_ep && (kind == TK_OUT || kind == TK_SETUP);
            if (!tok_ep && kind == TK_SETUP) begin
                d.ep0.stall = 1'b0;
                d.ep0.arm   = 1'b0;
            end
        end

        if (ack_hit) begin
            if (ack_ep) begin
                d.ep1.arm = 1'b0;
                d.irq1    = 1'b1;
            end else begin
                d.ep0.arm = 1'b0;
                d.irq0    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        if (reg_addr == EP0_ADDR)      reg_rdata = q.ep0;
        else if (reg_addr == EP1_ADDR) reg_rdata = q.ep1;
        else                           reg_rdata = 8'h00;
    end

    assign resp_valid  = q.rvalid;
    assign resp_code   = q.rcode;
    assign resp_cnt    = q.rcnt;
    assign resp_toggle = q.rtog;
    assign ep0_irq     = q.irq0;
    assign ep1_irq     = q.irq1;
endmodule

// File: rtl/usb_txhs_ctrl_chk.sv
module usb_txhs_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tok_valid,
    input logic [1:0] tok_kind,
    input logic       tok_ep,
    input logic       resp_valid,
    input logic [2:0] resp_code,
    input logic [3:0] resp_cnt,
    input logic       ep0_irq,
    input logic       ep1_irq,
    input logic [7:0] ep0_q,
    input logic [7:0] ep1_q
);
    // R3: byte count never exceeds eight
    p_cnt_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> resp_cnt <= 4'd8);

    // R5: stalled endpoint 0 stalls IN and OUT
    p_stall_ep0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && !tok_ep && tok_kind inside {2'd0, 2'd1} && ep0_q[5])
        |=> resp_code == 3'd3);

    // R6: SETUP on endpoint 0 clears stall and arm
    p_setup_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && !tok_ep && tok_kind == 2'd2) |=> (!ep0_q[5] && !ep0_q[7]));

    // R8: disabled endpoint 1 stays silent
    p_ep1_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_ep && !ep1_q[4]) |=> (!resp_valid && resp_code == 3'd0));

    // R9: interrupts are single-cycle pulses that coincide with disarm
    p_irq0_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ep0_irq |=> !ep0_irq);
    p_irq1_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ep1_irq |=> !ep1_irq);
    p_irq0_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ep0_irq |-> !ep0_q[7]);
    p_irq1_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ep1_irq |-> !ep1_q[7]);
endmodule

bind usb_txhs_ctrl usb_txhs_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tok_valid  (tok_valid),
    .tok_kind   (tok_kind),
    .tok_ep     (tok_ep),
    .resp_valid (resp_valid),
    .resp_code  (resp_code),
    .resp_cnt   (resp_cnt),
    .ep0_irq    (ep0_irq),
    .ep1_irq    (ep1_irq),
    .ep0_q      (ep0_q),
    .ep1_q      (ep1_q)
);

// File: tb/tb_usb_txhs_ctrl.sv
`timescale 1ns/1ps
module tb_usb_txhs_ctrl;
    localparam int TMO = 16;
    localparam int NV  = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       tok_valid = 1'b0;
    logic [1:0] tok_kind = 2'd0;
    logic       tok_ep = 1'b0;
    logic       host_ack = 1'b0;
    logic       rx_err = 1'b0;
    logic       resp_valid;
    logic [2:0] resp_code;
    logic [3:0] resp_cnt;
    logic       resp_toggle;
    logic       ep0_irq, ep1_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    usb_txhs_ctrl #(.ACK_TIMEOUT(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tok_valid(tok_valid),
        .tok_kind(tok_kind), .tok_ep(tok_ep), .host_ack(host_ack), .rx_err(rx_err),
        .resp_valid(resp_valid), .resp_code(resp_code), .resp_cnt(resp_cnt),
        .resp_toggle(resp_toggle), .ep0_irq(ep0_irq), .ep1_irq(ep1_irq)
    );

    // {ep0 byte, ep1 byte, kind, ep, code, cnt, toggle, pad}
    localparam logic [31:0] VEC [NV] = '{
        {8'h85, 8'h00, 2'd0, 1'b0, 3'd1, 4'd5, 1'b0, 5'd0},  // R3
        {8'hC8, 8'h00, 2'd0, 1'b0, 3'd1, 4'd8, 1'b1, 5'd0},  // R3
        {8'h8F, 8'h00, 2'd0, 1'b0, 3'd1, 4'd8, 1'b0, 5'd0},  // R3 clip
        {8'h03, 8'h00, 2'd0, 1'b0, 3'd2, 4'd0, 1'b0, 5'd0},  // R4
        {8'hA3, 8'h00, 2'd0, 1'b0, 3'd3, 4'd0, 1'b0, 5'd0},  // R5
        {8'h20, 8'h00, 2'd1, 1'b0, 3'd3, 4'd0, 1'b0, 5'd0},  // R5
        {8'h00, 8'h00, 2'd1, 1'b0, 3'd4, 4'd0, 1'b0, 5'd0},  // R11
        {8'h00, 8'hA5, 2'd0, 1'b1, 3'd0, 4'd0, 1'b0, 5'd0},  // R8
        {8'h00, 8'h94, 2'd0, 1'b1, 3'd1, 4'd4, 1'b0, 5'd0},  // R3
        {8'h00, 8'hD2, 2'd0, 1'b1, 3'd1, 4'd2, 1'b1, 5'd0},  // R3
        {8'h00, 8'h10, 2'd0, 1'b1, 3'd2, 4'd0, 1'b0, 5'd0},  // R4
        {8'h00, 8'h30, 2'd1, 1'b1, 3'd3, 4'd0, 1'b0, 5'd0},  // R5
        {8'h00, 8'h10, 2'd1, 1'b1, 3'd0, 4'd0, 1'b0, 5'd0},  // R11
        {8'h00, 8'h30, 2'd0, 1'b1, 3'd3, 4'd0, 1'b0, 5'd0},  // R5
        {8'h00, 8'h10, 2'd2, 1'b1, 3'd0, 4'd0, 1'b0, 5'd0}   // R6
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // leaves the caller on the falling edge right after the capturing edge
    task automatic tok(input logic [1:0] k, input logic e);
        @(negedge clk);
        tok_valid = 1'b1; tok_kind = k; tok_ep = e;
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic pulse_ack();
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
    endtask

    task automatic pulse_err();
        @(negedge clk);
        rx_err = 1'b1;
        @(negedge clk);
        rx_err = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h10, v); check("R1 ep0 byte", v, 8'h00);
        rd(8'h11, v); check("R1 ep1 byte", v, 8'h00);
        check("R1 outputs", {resp_valid, resp_code, ep0_irq, ep1_irq}, 0);

        // R2 readback
        wr(8'h10, 8'h5A); rd(8'h10, v); check("R2 ep0 readback", v, 8'h5A);
        wr(8'h11, 8'hA5); rd(8'h11, v); check("R2 ep1 readback", v, 8'hA5);
        wr(8'h12, 8'hFF); rd(8'h12, v); check("R2 unmapped", v, 8'h00);
        rd(8'h10, v); check("R2 ep0 untouched", v, 8'h5A);

        // vector table
        for (int i = 0; i < NV; i++) begin
            wr(8'h10, VEC[i][31:24]);
            wr(8'h11, VEC[i][23:16]);
            tok(VEC[i][15:14], VEC[i][13]);
            check($sformatf("vec%0d R3/R4/R5/R8/R11 code", i), resp_code, VEC[i][12:10]);
            check($sformatf("vec%0d valid", i), resp_valid, (VEC[i][12:10] != 3'd0));
            check($sformatf("vec%0d R3 cnt/tog", i), {resp_cnt, resp_toggle}, VEC[i][9:5]);
        end

        // R5 ep1 stall persists after stalling
        wr(8'h11, 8'h30);
        tok(2'd0, 1'b1);
        tok(2'd1, 1'b1);
        rd(8'h11, v); check("R5 ep1 stall held", v, 8'h30);

        // R6 SETUP clears stall and arm only
        wr(8'h10, 8'hE7);
        tok(2'd2, 1'b0);
        check("R6 setup ack", resp_code, 3'd4);
        rd(8'h10, v); check("R6 bits cleared", v, 8'h47);

        // R7 rx error inside and outside a data phase
        wr(8'h10, 8'h00);
        tok(2'd2, 1'b0);
        pulse_err();
        rd(8'h10, v); check("R7 err set after setup", v, 8'h10);
        wr(8'h10, 8'h00);
        tok(2'd1, 1'b0);
        pulse_err();
        rd(8'h10, v); check("R7 err set after out", v, 8'h10);
        wr(8'h10, 8'h00);
        tok(2'd0, 1'b0);
        pulse_err();
        rd(8'h10, v); check("R7 err ignored after in", v, 8'h00);

        // R9 ack within window on ep0
        wr(8'h10, 8'h83);
        tok(2'd0, 1'b0);
        check("R9 data sent", resp_code, 3'd1);
        pulse_ack();
        check("R9 ep0 irq", {ep0_irq, ep1_irq}, 2'b10);
        rd(8'h10, v); check("R9 ep0 disarmed", v, 8'h03);
        @(negedge clk);
        check("R9 ep0 irq single cycle", ep0_irq, 1'b0);

        // R9 ack on ep1
        wr(8'h11, 8'hD1);
        tok(2'd0, 1'b1);
        repeat (3) @(negedge clk);
        pulse_ack();
        check("R9 ep1 irq", {ep0_irq, ep1_irq}, 2'b01);
        rd(8'h11, v); check("R9 ep1 disarmed", v, 8'h51);

        // R10 late ack
        wr(8'h11, 8'h91);
        tok(2'd0, 1'b1);
        repeat (TMO + 4) @(negedge clk);
        pulse_ack();
        check("R10 late ack no irq", {ep0_irq, ep1_irq}, 2'b00);
        rd(8'h11, v); check("R10 still armed", v, 8'h91);
        tok(2'd0, 1'b1);
        check("R10 resend", {resp_code, resp_cnt}, {3'd1, 4'd1});

        // R10 ack with nothing outstanding
        wr(8'h10, 8'h02);
        tok(2'd0, 1'b0);
        pulse_ack();
        check("R10 stray ack", {ep0_irq, ep1_irq}, 2'b00);

        // R8 disabled ep1 ignores ack and keeps its arm bit
        wr(8'h11, 8'h81);
        tok(2'd0, 1'b1);
        pulse_ack();
        rd(8'h11, v); check("R8 disabled ep1 unchanged", {v, ep1_irq}, {8'h81, 1'b0});

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule